// File: doc/BRIEF.md
# Serial Fast-Scan Status Responder

This block is the slave end of a byte-framed synchronous serial control port. The port has four pins: an active-low chip select, a data clock, serial data in and serial data out. The block answers one command only, the fast scan. It reads the two low bits of each of four per-channel control bytes and returns all eight bits in a single reply byte. A local write port loads the four control bytes.

A host transaction has these steps:
1. The host lowers chip select and clocks in the opcode byte, then releases chip select.
2. The host keeps toggling the data clock through a processing window and then a wait window.
3. The host lowers chip select again and clocks the reply out.
4. The host gives finishing and gap cycles before it starts the next frame.

All windows are counted in data-clock rising edges, never in system-clock time. The data clock may therefore run continuously or with gaps. The serial pins are oversampled by the system clock `clk`.

Top module: `fast_scan_responder`

## Requirements
- R1: After reset, `dout_oe` is low and `early_err` is low.
- R2: A command frame of eight bits equal to 8'b00000010 is accepted. Bits are sent MSB first and sampled on rising data-clock edges. A later read frame then drives the reply MSB first on `dout`, and `dout` changes only after falling data-clock edges.
- R3: Reply bit 2n is bit 0 of channel n's control byte, and reply bit 2n+1 is bit 1 of it, for n = 0..3. Bits 7..2 of the control bytes have no effect.
- R4: The command is ignored if its byte is any other value, or if chip select rises before exactly eight bits are clocked in. The next frame then never enables `dout`.
- R5: The reply is captured on the second rising data-clock edge after chip select rises at the end of the command. Control-byte writes after that point do not change this reply.
- R6: A read frame may begin after fewer than WAIT_CYC (default 10) rising edges counted from the release of chip select. That frame shifts out all zeros, and `early_err` is set and stays set until reset. With exactly WAIT_CYC edges the read is normal.
- R7: `dout_oe` is high only during a read frame that follows an accepted command, and only while chip select is low.
- R8: After a reply frame, FINISH_CYC+GAP_CYC (default 4) rising edges with chip select high must pass before a chip-select fall starts a new command. After an ignored command, GAP_CYC edges must pass. A frame started earlier is ignored.
- R9: All sequencing depends only on data-clock edges, so a gapped (slow, irregular) data clock gives the same results.
- R10: A local write with `wr_en` high stores `wr_data` into the control byte selected by `wr_ch` on that `clk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| dclk | input | 1 | Serial data clock |
| din | input | 1 | Serial data in, sampled on dclk rise |
| dout | output | 1 | Serial data out, updated after dclk fall |
| dout_oe | output | 1 | Output enable for dout (high-impedance when low) |
| early_err | output | 1 | Sticky flag: reply clocked before the wait finished |
| wr_en | input | 1 | Local control-byte write strobe |
| wr_ch | input | 2 | Channel selected for the local write |
| wr_data | input | 8 | Control byte to write |

## Verification
Four properties are checked on every cycle:
- `dout` holds steady while enabled except right after a data-clock fall.
- An early read drives only zeros.
- The error flag never clears by itself.
- The output enable can rise only from the wait state.

The bench scenarios cover the rest: bit packing across channels, rejection of wrong or truncated opcodes, the snapshot point versus later writes, the exact wait boundary (9 versus 10 edges), the inter-frame gap, and correct behaviour with a gapped data clock.

// File: rtl/fast_scan_responder.sv
module fast_scan_responder #(
  parameter int NCH        = 4,
  parameter int WAIT_CYC   = 10,
  parameter int PROC_CYC   = 2,
  parameter int FINISH_CYC = 2,
  parameter int GAP_CYC    = 2,
  parameter logic [7:0] OPCODE = 8'h02
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_n,
  input  logic                     dclk,
  input  logic                     din,
  output logic                     dout,
  output logic                     dout_oe,
  output logic                     early_err,
  input  logic                     wr_en,
  input  logic [$clog2(NCH)-1:0]   wr_ch,
  input  logic [7:0]               wr_data
);
  localparam int RW = 2 * NCH;
  localparam int CW = $clog2(WAIT_CYC + FINISH_CYC + GAP_CYC + RW + 16);
  localparam logic [CW-1:0] WAIT_LIM = CW'(WAIT_CYC);
  localparam logic [CW-1:0] SNAP_AT  = CW'(PROC_CYC - 1);
  localparam logic [CW-1:0] POST_DAT = CW'(FINISH_CYC + GAP_CYC);
  localparam logic [CW-1:0] POST_IGN = CW'(GAP_CYC);
  localparam logic [CW-1:0] RW_C     = CW'(RW);
  localparam logic [CW-1:0] BYTE_C   = CW'(8);
  localparam logic [CW-1:0] OVER_C   = CW'(9);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_WAIT, S_DATA, S_POST} st_t;

  st_t              st;
  logic             dclk_q, cs_q, early_q;
  logic [7:0]       chreg [NCH];
  logic [7:0]       cmd_sr;
  logic [CW-1:0]    cnt, post_len;
  logic [RW-1:0]    snap, shreg, gath;

  wire rise    = dclk & ~dclk_q;
  wire fall    = ~dclk & dclk_q;
  wire cs_fall = ~cs_n & cs_q;
  wire cs_rise = cs_n & ~cs_q;

  always_comb
    for (int n = 0; n < NCH; n++) gath[2*n +: 2] = chreg[n][1:0];

  assign dout    = shreg[RW-1];
  assign dout_oe = (st == S_DATA) && !cs_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < NCH; n++) chreg[n] <= '0;
    end else if (wr_en) begin
      chreg[wr_ch] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; dclk_q <= 1'b0; cs_q <= 1'b1; early_q <= 1'b0;
      cmd_sr <= '0; cnt <= '0; post_len <= '0; snap <= '0; shreg <= '0;
      early_err <= 1'b0;
    end else begin
      dclk_q <= dclk;
      cs_q   <= cs_n;
      case (st)
        S_IDLE: if (cs_fall) begin st <= S_CMD; cnt <= '0; end
        S_CMD: begin
          if (cs_rise) begin
            cnt <= '0;
            if (cnt == BYTE_C && cmd_sr == OPCODE) st <= S_WAIT;
            else begin st <= S_POST; post_len <= POST_IGN; end
          end else if (rise && !cs_n) begin
            cmd_sr <= {cmd_sr[6:0], din};
            if (cnt != OVER_C) cnt <= cnt + CW'(1);
          end
        end
        S_WAIT: begin
          if (cs_fall) begin
            st      <= S_DATA;
            cnt     <= '0;
            early_q <= cnt < WAIT_LIM;
            shreg   <= (cnt < WAIT_LIM) ? '0 : snap;
            if (cnt < WAIT_LIM) early_err <= 1'b1;
          end else if (rise && cs_n) begin
            if (cnt < WAIT_LIM) cnt <= cnt + CW'(1);
            if (cnt == SNAP_AT) snap <= gath;
          end
        end
        S_DATA: begin
          if (cs_rise) begin
            st <= S_POST; cnt <= '0; post_len <= POST_DAT;
          end else if (!cs_n) begin
            if (rise && cnt < RW_C) cnt <= cnt + CW'(1);
            if (fall && cnt != '0 && cnt < RW_C) shreg <= shreg << 1;
          end
        end
        S_POST: if (rise && cs_n) begin
          cnt <= cnt + CW'(1);
          if (cnt + CW'(1) >= post_len) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  dout_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && $past(dout_oe) && !$past(fall)) |-> $stable(dout));
  // R6
  early_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && early_q) |-> !dout);
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    early_err |=> early_err);
  // R7
  oe_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> $past(st) == S_WAIT);
endmodule

// File: tb/fast_scan_responder_tb.sv
module fast_scan_responder_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, dclk = 1'b0, din = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_ch = '0;
  logic [7:0] wr_data = '0;
  logic dout, dout_oe, early_err;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [8:0] exp_q[$];
  logic [8:0] got_q[$];
  string      tag_q[$];
  logic [7:0] regs [4];

  always #4 clk = ~clk;

  fast_scan_responder u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dclk(dclk), .din(din),
    .dout(dout), .dout_oe(dout_oe), .early_err(early_err),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit b, input int lo);
    din = b; tick(lo); dclk = 1'b1; tick(4); dclk = 1'b0;
  endtask

  task automatic wr(input int ch, input logic [7:0] v);
    wr_ch = 2'(ch); wr_data = v; wr_en = 1'b1; tick(1); wr_en = 1'b0;
    regs[ch] = v;
  endtask

  function automatic logic [7:0] pack();
    logic [7:0] r;
    for (int n = 0; n < 4; n++) r[2*n +: 2] = regs[n][1:0];
    return r;
  endfunction

  task automatic cmd_frame(input logic [7:0] c, input int nbits, input int lo);
    cs_n = 1'b0; tick(2);
    for (int i = 7; i > 7 - nbits; i--) pulse(c[i], lo);
    tick(4); cs_n = 1'b1; tick(2);
  endtask

  task automatic idle(input int n, input int lo);
    for (int i = 0; i < n; i++) pulse(1'b0, lo);
  endtask

  task automatic expect_item(input bit oe, input logic [7:0] v, input string tag);
    exp_q.push_back({oe, v}); tag_q.push_back(tag);
  endtask

  task automatic read_frame(input int lo);
    logic [7:0] v; bit oe_any;
    v = '0; oe_any = 1'b0;
    cs_n = 1'b0; tick(2);
    for (int i = 7; i >= 0; i--) begin
      din = 1'b0; tick(lo);
      oe_any |= dout_oe;
      v[i] = dout_oe ? dout : 1'b0;
      dclk = 1'b1; tick(4); dclk = 1'b0;
    end
    tick(4); cs_n = 1'b1; tick(2);
    got_q.push_back({oe_any, v});
  endtask

  always @(negedge clk) begin
    if (got_q.size() > 0 && exp_q.size() > 0) begin
      logic [8:0] g, e; string t;
      g = got_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      chk(g == e, t, int'(g), int'(e));
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] old;
    for (int n = 0; n < 4; n++) regs[n] = '0;
    tick(5); rst_n = 1'b1; tick(3);
    // R1 reset state
    chk(dout_oe == 1'b0, "R1 oe", int'(dout_oe), 0);
    chk(early_err == 1'b0, "R1 err", int'(early_err), 0);

    // R10 R3: only bits 1:0 of each channel count
    wr(0, 8'hFD); wr(1, 8'h06); wr(2, 8'h0F); wr(3, 8'hF0);
    // R2 basic scan, continuous clock
    cmd_frame(8'h02, 8, 4); idle(10, 4);
    chk(dout_oe == 1'b0, "R7 oe low in wait", int'(dout_oe), 0);
    expect_item(1'b1, pack(), "R2 R3 basic reply"); read_frame(4);
    chk(dout_oe == 1'b0, "R7 oe low after frame", int'(dout_oe), 0);
    idle(4, 4);

    // R9 gapped clock with new pattern (R8: exactly 4 gap edges suffice)
    wr(0, 8'h02); wr(1, 8'h01); wr(2, 8'h00); wr(3, 8'h03);
    cmd_frame(8'h02, 8, 13); idle(10, 17);
    expect_item(1'b1, pack(), "R9 gapped reply"); read_frame(11);
    idle(4, 9);

    // R4 wrong opcodes and truncated opcode
    cmd_frame(8'h03, 8, 4); idle(10, 4);
    expect_item(1'b0, 8'h00, "R4 opcode 03 ignored"); read_frame(4); idle(4, 4);
    cmd_frame(8'h42, 8, 4); idle(10, 4);
    expect_item(1'b0, 8'h00, "R4 opcode 42 ignored"); read_frame(4); idle(4, 4);
    cmd_frame(8'h02, 5, 4); idle(10, 4);
    expect_item(1'b0, 8'h00, "R4 truncated ignored"); read_frame(4); idle(4, 4);
    chk(early_err == 1'b0, "R4 err untouched", int'(early_err), 0);

    // R5 snapshot at second edge, later writes ignored for this reply
    wr(0, 8'h03); wr(1, 8'h00); wr(2, 8'h02); wr(3, 8'h01);
    old = pack();
    cmd_frame(8'h02, 8, 4); idle(3, 4);
    wr(0, 8'h00); wr(1, 8'h03); wr(2, 8'h01); wr(3, 8'h02);
    idle(7, 4);
    expect_item(1'b1, old, "R5 snapshot kept"); read_frame(4); idle(4, 4);
    cmd_frame(8'h02, 8, 4); idle(10, 4);
    expect_item(1'b1, pack(), "R5 new values next scan"); read_frame(4); idle(4, 4);
    chk(early_err == 1'b0, "R6 no err at exact wait", int'(early_err), 0);

    // R6 early read: 9 edges only
    cmd_frame(8'h02, 8, 4); idle(9, 4);
    expect_item(1'b1, 8'h00, "R6 early zeros"); read_frame(4);
    chk(early_err == 1'b1, "R6 err set", int'(early_err), 1);
    idle(4, 4);
    cmd_frame(8'h02, 8, 4); idle(10, 4);
    expect_item(1'b1, pack(), "R6 normal after early"); read_frame(4);
    chk(early_err == 1'b1, "R6 err sticky", int'(early_err), 1);

    // R8 gap too short (3 edges): next command ignored
    idle(3, 4);
    cmd_frame(8'h02, 8, 4); idle(10, 4);
    expect_item(1'b0, 8'h00, "R8 short gap ignored"); read_frame(4); idle(4, 4);
    cmd_frame(8'h02, 8, 4); idle(10, 4);
    expect_item(1'b1, pack(), "R8 recovered"); read_frame(4); idle(4, 4);

    while (exp_q.size() > 0 || got_q.size() > 0) begin
      if (exp_q.size() == 0 || got_q.size() == 0) begin
        chk(1'b0, "scoreboard drain", got_q.size(), exp_q.size());
        break;
      end
      tick(1);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule